// File: doc/BRIEF.md
# Configuration Write Data Error Responder

This block sits on the target side of a split-transaction parallel bus. It watches configuration writes that have finished their data phase. Every such write is accepted and ends in a split response. A write whose data carried an uncorrectable error is also kept off the internal bus. When the parity-error response enable is set, a delayed active-low parity-error strobe follows. A split completion error message addressed to the original requester is queued for the bus side. The block keeps sticky detected-error and interrupt-status bits, which software clears by writing ones. In the higher-speed bus mode it also holds a log of the first failing transaction.

An upstream decoder presents each write for one cycle on `txn_valid_i`, together with the error flag and the transaction attributes. A message serializer takes requests over a valid/ready handshake. Register access logic drives the enable, the masks and the write-one-to-clear pulses.

Top module: `cfg_wr_err_responder`

## Requirements
- R1: Every configuration write sampled on `txn_valid_i` produces a one-cycle `term_split_o` pulse in the next cycle, whether or not its data is in error.
- R2: A write with `txn_ue_i` set never raises `fwd_valid_o`. A clean write raises `fwd_valid_o` in the cycle after sampling, with its low address on `fwd_addr_o`.
- R3: When `perr_resp_en_i` is set at sampling, `perr_no` is driven low for exactly one cycle, three cycles after the `term_split_o` cycle. When it is clear, `perr_no` stays high.
- R4: Erroneous writes in consecutive cycles each produce their own low cycle on `perr_no`, giving back-to-back low cycles.
- R5: In the cycle `perr_no` goes low, a message request is raised (when the slot is free) with class 4'h2, index 8'h01 and the requester ID of the failing write. It stays valid and stable until `msg_ready_i` is high at a clock edge.
- R6: `isr_scem_o` is set in the cycle `perr_no` goes low, but only when `scem_mask_i` is low. With the mask high it stays unchanged.
- R7: `sts_dpe_o` is set in the cycle after any erroneous write is sampled, regardless of `perr_resp_en_i`.
- R8: `isr_dpe_o` is set together with `sts_dpe_o`, but only when `dpe_mask_i` is low.
- R9: The sticky bits clear only when a one is written to their own position of `clr_i`: bit 0 `sts_dpe_o`, bit 1 `isr_dpe_o`, bit 2 `isr_scem_o`, bit 3 `msg_ovf_o`, bit 4 the error log. Other bits are untouched.
- R10: A new message request that arrives while the previous one is still pending sets `msg_ovf_o`. The new request is dropped and the pending message is kept.
- R11: With `mode2_i` high, the first erroneous write loads the error log (`ecc_vld_o`, requester ID, low and high address, attributes). Later errors leave the log unchanged until it is cleared. With `mode2_i` low, nothing is logged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| txn_valid_i | input | 1 | Configuration write data phase complete |
| txn_ue_i | input | 1 | Uncorrectable data error on that write |
| txn_req_id_i | input | 16 | Requester ID of the write |
| txn_addr_lo_i | input | ADDR_W | Low address word |
| txn_addr_hi_i | input | ADDR_W | High address word |
| txn_attr_i | input | ATTR_W | Transaction attributes |
| mode2_i | input | 1 | Higher-speed bus mode, enables error logging |
| perr_resp_en_i | input | 1 | Parity-error response enable |
| scem_mask_i | input | 1 | Mask for the initiated-message interrupt bit |
| dpe_mask_i | input | 1 | Mask for the detected-error interrupt bit |
| clr_i | input | 5 | Write-one-to-clear pulses |
| term_split_o | output | 1 | Split response termination |
| fwd_valid_o | output | 1 | Forward write to internal bus |
| fwd_addr_o | output | ADDR_W | Address of forwarded write |
| perr_no | output | 1 | Parity-error strobe, active low |
| msg_valid_o | output | 1 | Error message request valid |
| msg_ready_i | input | 1 | Error message request accepted |
| msg_req_id_o | output | 16 | Requester addressed by the message |
| msg_class_o | output | 4 | Message class |
| msg_index_o | output | 8 | Message index |
| sts_dpe_o | output | 1 | Detected parity error status |
| isr_dpe_o | output | 1 | Detected parity error interrupt status |
| isr_scem_o | output | 1 | Initiated split completion error message interrupt status |
| msg_ovf_o | output | 1 | Message request overflow |
| ecc_vld_o | output | 1 | Error log holds a transaction |
| ecc_req_id_o | output | 16 | Logged requester ID |
| ecc_addr_lo_o | output | ADDR_W | Logged low address |
| ecc_addr_hi_o | output | ADDR_W | Logged high address |
| ecc_attr_o | output | ATTR_W | Logged attributes |

## Verification
A stage dropped or added in the delay line shows at once as `perr_no` going low one cycle early or late, relative to `term_split_o`. A stale requester ID in the pipeline shows as a message with the wrong ID, which the scoreboard catches when the handshake completes. A sticky bit that sets under the wrong mask or clears at the wrong position shows on the status pins in the first cycle after the error or the clear pulse. A message slot that overwrites instead of flagging overflow delivers a message the scoreboard never expected.

// File: rtl/cwer_pkg.sv
package cwer_pkg;
  localparam int REQ_ID_W = 16;
  localparam int CLS_W    = 4;
  localparam int IDX_W    = 8;
  localparam logic [CLS_W-1:0] MSG_CLASS_COMPLETER = 4'h2;
  localparam logic [IDX_W-1:0] MSG_IDX_UNCORR_WR   = 8'h01;
  localparam int CLR_DPE      = 0;
  localparam int CLR_ISR_DPE  = 1;
  localparam int CLR_ISR_SCEM = 2;
  localparam int CLR_OVF      = 3;
  localparam int CLR_ECC      = 4;
  localparam int CLR_W        = 5;
  localparam int STICKY_N     = 4;

  typedef struct packed {
    logic [REQ_ID_W-1:0] req_id;
    logic [CLS_W-1:0]    cls;
    logic [IDX_W-1:0]    idx;
  } err_msg_t;
endpackage

// File: rtl/cwer_delay_pipe.sv
module cwer_delay_pipe #(
  parameter int DELAY = 3,
  parameter int ID_W  = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fire_i,
  input  logic [ID_W-1:0] id_i,
  output logic            fire_o,
  output logic [ID_W-1:0] id_o
);
  logic            st_q [DELAY];
  logic [ID_W-1:0] id_q [DELAY];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q[0] <= 1'b0;
      id_q[0] <= '0;
    end else begin
      st_q[0] <= fire_i;
      id_q[0] <= fire_i ? id_i : '0;
    end
  end

  for (genvar i = 1; i < DELAY; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q[i] <= 1'b0;
        id_q[i] <= '0;
      end else begin
        st_q[i] <= st_q[i-1];
        id_q[i] <= id_q[i-1];
      end
    end
  end

  assign fire_o = st_q[DELAY-1];
  assign id_o   = id_q[DELAY-1];
endmodule

// File: rtl/cwer_msg_slot.sv
module cwer_msg_slot import cwer_pkg::*; (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                push_i,
  input  logic [REQ_ID_W-1:0] push_id_i,
  input  logic                ready_i,
  output logic                valid_o,
  output err_msg_t            msg_o,
  output logic                ovf_o
);
  logic     valid_q;
  err_msg_t msg_q;
  logic     free;

  assign free = !valid_q || ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      msg_q   <= '0;
    end else if (push_i && free) begin
      valid_q     <= 1'b1;
      msg_q.req_id <= push_id_i;
      msg_q.cls    <= MSG_CLASS_COMPLETER;
      msg_q.idx    <= MSG_IDX_UNCORR_WR;
    end else if (valid_q && ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign msg_o   = msg_q;
  assign ovf_o   = push_i && !free;
endmodule

// File: rtl/cwer_err_log.sv
module cwer_err_log import cwer_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int ATTR_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cap_i,
  input  logic                clr_i,
  input  logic [REQ_ID_W-1:0] id_i,
  input  logic [ADDR_W-1:0]   addr_lo_i,
  input  logic [ADDR_W-1:0]   addr_hi_i,
  input  logic [ATTR_W-1:0]   attr_i,
  output logic                vld_o,
  output logic [REQ_ID_W-1:0] id_o,
  output logic [ADDR_W-1:0]   addr_lo_o,
  output logic [ADDR_W-1:0]   addr_hi_o,
  output logic [ATTR_W-1:0]   attr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o     <= 1'b0;
      id_o      <= '0;
      addr_lo_o <= '0;
      addr_hi_o <= '0;
      attr_o    <= '0;
    end else if (cap_i && !vld_o) begin
      // first failure wins; held until cleared
      vld_o     <= 1'b1;
      id_o      <= id_i;
      addr_lo_o <= addr_lo_i;
      addr_hi_o <= addr_hi_i;
      attr_o    <= attr_i;
    end else if (clr_i) begin
      vld_o <= 1'b0;
    end
  end
endmodule

// File: rtl/cfg_wr_err_responder.sv
module cfg_wr_err_responder import cwer_pkg::*; #(
  parameter int ADDR_W     = 32,
  parameter int ATTR_W     = 32,
  parameter int PERR_DELAY = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                txn_valid_i,
  input  logic                txn_ue_i,
  input  logic [REQ_ID_W-1:0] txn_req_id_i,
  input  logic [ADDR_W-1:0]   txn_addr_lo_i,
  input  logic [ADDR_W-1:0]   txn_addr_hi_i,
  input  logic [ATTR_W-1:0]   txn_attr_i,
  input  logic                mode2_i,
  input  logic                perr_resp_en_i,
  input  logic                scem_mask_i,
  input  logic                dpe_mask_i,
  input  logic [CLR_W-1:0]    clr_i,
  output logic                term_split_o,
  output logic                fwd_valid_o,
  output logic [ADDR_W-1:0]   fwd_addr_o,
  output logic                perr_no,
  output logic                msg_valid_o,
  input  logic                msg_ready_i,
  output logic [REQ_ID_W-1:0] msg_req_id_o,
  output logic [CLS_W-1:0]    msg_class_o,
  output logic [IDX_W-1:0]    msg_index_o,
  output logic                sts_dpe_o,
  output logic                isr_dpe_o,
  output logic                isr_scem_o,
  output logic                msg_ovf_o,
  output logic                ecc_vld_o,
  output logic [REQ_ID_W-1:0] ecc_req_id_o,
  output logic [ADDR_W-1:0]   ecc_addr_lo_o,
  output logic [ADDR_W-1:0]   ecc_addr_hi_o,
  output logic [ATTR_W-1:0]   ecc_attr_o
);
  logic                det_err;
  logic                pipe_fire;
  logic [REQ_ID_W-1:0] pipe_id;
  logic                perr_q;
  logic                ovf_pulse;
  err_msg_t            msg;
  logic [STICKY_N-1:0] sticky_set;
  logic [STICKY_N-1:0] sticky_clr;
  logic [STICKY_N-1:0] sticky_q;

  assign det_err = txn_valid_i && txn_ue_i;

  // split termination for every write; forward only clean data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      term_split_o <= 1'b0;
      fwd_valid_o  <= 1'b0;
      fwd_addr_o   <= '0;
    end else begin
      term_split_o <= txn_valid_i;
      fwd_valid_o  <= txn_valid_i && !txn_ue_i;
      if (txn_valid_i && !txn_ue_i) fwd_addr_o <= txn_addr_lo_i;
    end
  end

  cwer_delay_pipe #(.DELAY(PERR_DELAY), .ID_W(REQ_ID_W)) u_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (det_err && perr_resp_en_i),
    .id_i   (txn_req_id_i),
    .fire_o (pipe_fire),
    .id_o   (pipe_id)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) perr_q <= 1'b0;
    else         perr_q <= pipe_fire;
  end
  assign perr_no = !perr_q;

  cwer_msg_slot u_slot (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (pipe_fire),
    .push_id_i (pipe_id),
    .ready_i   (msg_ready_i),
    .valid_o   (msg_valid_o),
    .msg_o     (msg),
    .ovf_o     (ovf_pulse)
  );
  assign msg_req_id_o = msg.req_id;
  assign msg_class_o  = msg.cls;
  assign msg_index_o  = msg.idx;

  assign sticky_set[CLR_DPE]      = det_err;
  assign sticky_set[CLR_ISR_DPE]  = det_err && !dpe_mask_i;
  assign sticky_set[CLR_ISR_SCEM] = pipe_fire && !scem_mask_i;
  assign sticky_set[CLR_OVF]      = ovf_pulse;
  assign sticky_clr = clr_i[STICKY_N-1:0];

  for (genvar b = 0; b < STICKY_N; b++) begin : g_sticky
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            sticky_q[b] <= 1'b0;
      else if (sticky_set[b]) sticky_q[b] <= 1'b1;
      else if (sticky_clr[b]) sticky_q[b] <= 1'b0;
    end
  end

  assign sts_dpe_o  = sticky_q[CLR_DPE];
  assign isr_dpe_o  = sticky_q[CLR_ISR_DPE];
  assign isr_scem_o = sticky_q[CLR_ISR_SCEM];
  assign msg_ovf_o  = sticky_q[CLR_OVF];

  cwer_err_log #(.ADDR_W(ADDR_W), .ATTR_W(ATTR_W)) u_log (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cap_i     (det_err && mode2_i),
    .clr_i     (clr_i[CLR_ECC]),
    .id_i      (txn_req_id_i),
    .addr_lo_i (txn_addr_lo_i),
    .addr_hi_i (txn_addr_hi_i),
    .attr_i    (txn_attr_i),
    .vld_o     (ecc_vld_o),
    .id_o      (ecc_req_id_o),
    .addr_lo_o (ecc_addr_lo_o),
    .addr_hi_o (ecc_addr_hi_o),
    .attr_o    (ecc_attr_o)
  );
endmodule

// File: rtl/cwer_checker.sv
module cwer_checker import cwer_pkg::*; (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                txn_valid_i,
  input logic                txn_ue_i,
  input logic                perr_resp_en_i,
  input logic                term_split_o,
  input logic                fwd_valid_o,
  input logic                perr_no,
  input logic                msg_valid_o,
  input logic                msg_ready_i,
  input logic [REQ_ID_W-1:0] msg_req_id_o,
  input logic [CLS_W-1:0]    msg_class_o,
  input logic [IDX_W-1:0]    msg_index_o,
  input logic                sts_dpe_o
);
  AST_TERM_EVERY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_i |=> term_split_o); // R1
  AST_NO_FWD_ON_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txn_valid_i && txn_ue_i) |=> !fwd_valid_o); // R2
  AST_PERR_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txn_valid_i && txn_ue_i && perr_resp_en_i) |-> ##4 !perr_no); // R3
  AST_PERR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !perr_no |-> $past(txn_valid_i && txn_ue_i && perr_resp_en_i, 4)); // R3
  AST_MSG_WITH_PERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !perr_no |-> msg_valid_o); // R5
  AST_MSG_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> (msg_class_o == 4'h2 && msg_index_o == 8'h01)); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && !msg_ready_i) |=> (msg_valid_o && $stable(msg_req_id_o))); // R10
  AST_DPE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txn_valid_i && txn_ue_i) |=> sts_dpe_o); // R7
endmodule

bind cfg_wr_err_responder cwer_checker u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .txn_valid_i    (txn_valid_i),
  .txn_ue_i       (txn_ue_i),
  .perr_resp_en_i (perr_resp_en_i),
  .term_split_o   (term_split_o),
  .fwd_valid_o    (fwd_valid_o),
  .perr_no        (perr_no),
  .msg_valid_o    (msg_valid_o),
  .msg_ready_i    (msg_ready_i),
  .msg_req_id_o   (msg_req_id_o),
  .msg_class_o    (msg_class_o),
  .msg_index_o    (msg_index_o),
  .sts_dpe_o      (sts_dpe_o)
);

// File: tb/cfg_wr_err_responder_tb.sv
module cfg_wr_err_responder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        txn_valid = 1'b0, txn_ue = 1'b0;
  logic [15:0] txn_id = '0;
  logic [31:0] addr_lo = '0, addr_hi = '0, attr = '0;
  logic        mode2 = 1'b0, perr_en = 1'b1, scem_mask = 1'b0, dpe_mask = 1'b0;
  logic [4:0]  clr = '0;
  logic        msg_ready = 1'b1;

  logic        term_split, fwd_valid, perr_n, msg_valid;
  logic [31:0] fwd_addr;
  logic [15:0] msg_id;
  logic [3:0]  msg_class;
  logic [7:0]  msg_index;
  logic        sts_dpe, isr_dpe, isr_scem, msg_ovf, ecc_vld;
  logic [15:0] ecc_id;
  logic [31:0] ecc_lo, ecc_hi, ecc_attr;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_q[$];

  always #5 clk = ~clk;

  cfg_wr_err_responder u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .txn_valid_i(txn_valid), .txn_ue_i(txn_ue), .txn_req_id_i(txn_id),
    .txn_addr_lo_i(addr_lo), .txn_addr_hi_i(addr_hi), .txn_attr_i(attr),
    .mode2_i(mode2), .perr_resp_en_i(perr_en), .scem_mask_i(scem_mask),
    .dpe_mask_i(dpe_mask), .clr_i(clr),
    .term_split_o(term_split), .fwd_valid_o(fwd_valid), .fwd_addr_o(fwd_addr),
    .perr_no(perr_n), .msg_valid_o(msg_valid), .msg_ready_i(msg_ready),
    .msg_req_id_o(msg_id), .msg_class_o(msg_class), .msg_index_o(msg_index),
    .sts_dpe_o(sts_dpe), .isr_dpe_o(isr_dpe), .isr_scem_o(isr_scem),
    .msg_ovf_o(msg_ovf), .ecc_vld_o(ecc_vld), .ecc_req_id_o(ecc_id),
    .ecc_addr_lo_o(ecc_lo), .ecc_addr_hi_o(ecc_hi), .ecc_attr_o(ecc_attr)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pop expected message on each handshake
  always @(negedge clk) begin
    if (rst_n && msg_valid && msg_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R10 unexpected message actual=%0h expected=none", msg_id);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        if (msg_id !== e || msg_class !== 4'h2 || msg_index !== 8'h01) begin
          errors++;
          $display("FAIL R5 message actual=%0h/%0h/%0h expected=%0h/2/1",
                   msg_id, msg_class, msg_index, e);
        end
      end
    end
  end

  // one write; checks termination, forward, strobe timing
  task automatic wr(input bit ue, input logic [15:0] id, input logic [31:0] lo, input bit push);
    bit exp_perr;
    exp_perr = ue && perr_en;
    @(posedge clk); #1;
    txn_valid = 1'b1; txn_ue = ue; txn_id = id; addr_lo = lo;
    addr_hi = ~lo; attr = {16'h0, id};
    if (push) exp_q.push_back(id);
    @(posedge clk); #1;
    txn_valid = 1'b0; txn_ue = 1'b0;
    @(negedge clk);
    chk(term_split === 1'b1, "R1 term", term_split, 1);
    chk(fwd_valid === !ue, "R2 fwd", fwd_valid, !ue);
    if (!ue) chk(fwd_addr === lo, "R2 fwd_addr", fwd_addr, lo);
    if (ue) chk(sts_dpe === 1'b1, "R7 sts_dpe", sts_dpe, 1);
    @(negedge clk);
    chk(term_split === 1'b0, "R1 term pulse", term_split, 0);
    @(negedge clk);
    chk(perr_n === 1'b1, "R3 early", perr_n, 1);
    @(negedge clk);
    chk(perr_n === !exp_perr, "R3 strobe", perr_n, !exp_perr);
    if (exp_perr) chk(msg_valid === 1'b1, "R5 msg with strobe", msg_valid, 1);
    @(negedge clk);
    chk(perr_n === 1'b1, "R3 one cycle", perr_n, 1);
  endtask

  task automatic clear(input logic [4:0] bits);
    @(posedge clk); #1 clr = bits;
    @(posedge clk); #1 clr = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(perr_n === 1'b1 && msg_valid === 1'b0, "R3 reset", {perr_n, msg_valid}, 2'b10);
    chk({sts_dpe, isr_dpe, isr_scem, msg_ovf, ecc_vld} === 5'b0, "R9 reset",
        {sts_dpe, isr_dpe, isr_scem, msg_ovf, ecc_vld}, 0);

    // clean write
    wr(1'b0, 16'h0101, 32'hA000_0010, 1'b0);
    chk(sts_dpe === 1'b0, "R7 clean no status", sts_dpe, 0);

    // error with enable, masks clear
    wr(1'b1, 16'h0A0B, 32'hA000_0020, 1'b1);
    chk(isr_dpe === 1'b1, "R8 isr_dpe", isr_dpe, 1);
    chk(isr_scem === 1'b1, "R6 isr_scem", isr_scem, 1);

    // W1C one bit at a time
    clear(5'b00001);
    @(negedge clk);
    chk(sts_dpe === 1'b0 && isr_dpe === 1'b1 && isr_scem === 1'b1, "R9 clear bit0",
        {sts_dpe, isr_dpe, isr_scem}, 3'b011);
    clear(5'b00110);
    @(negedge clk);
    chk(isr_dpe === 1'b0 && isr_scem === 1'b0, "R9 clear bits1-2", {isr_dpe, isr_scem}, 0);

    // enable clear: status still set, no strobe, no message
    perr_en = 1'b0;
    wr(1'b1, 16'h0C0C, 32'hA000_0030, 1'b0);
    chk(isr_dpe === 1'b1 && isr_scem === 1'b0, "R6 R8 no enable",
        {isr_dpe, isr_scem}, 2'b10);
    perr_en = 1'b1;
    clear(5'b00111);

    // masks set
    scem_mask = 1'b1; dpe_mask = 1'b1;
    wr(1'b1, 16'h0D0D, 32'hA000_0040, 1'b1);
    chk(sts_dpe === 1'b1, "R7 masked status", sts_dpe, 1);
    chk(isr_dpe === 1'b0, "R8 masked", isr_dpe, 0);
    chk(isr_scem === 1'b0, "R6 masked", isr_scem, 0);
    scem_mask = 1'b0; dpe_mask = 1'b0;
    clear(5'b00111);

    // back-to-back errors
    @(posedge clk); #1;
    txn_valid = 1'b1; txn_ue = 1'b1; txn_id = 16'h1111; exp_q.push_back(16'h1111);
    @(posedge clk); #1;
    txn_id = 16'h2222; exp_q.push_back(16'h2222);
    @(posedge clk); #1;
    txn_valid = 1'b0; txn_ue = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(perr_n === 1'b1, "R4 before", perr_n, 1);
    @(negedge clk);
    chk(perr_n === 1'b0, "R4 first", perr_n, 0);
    @(negedge clk);
    chk(perr_n === 1'b0, "R4 second", perr_n, 0);
    @(negedge clk);
    chk(perr_n === 1'b1, "R4 after", perr_n, 1);
    clear(5'b00111);

    // overflow
    @(posedge clk); #1 msg_ready = 1'b0;
    wr(1'b1, 16'h3333, 32'hA000_0050, 1'b1);
    chk(msg_ovf === 1'b0, "R10 no ovf yet", msg_ovf, 0);
    wr(1'b1, 16'h4444, 32'hA000_0060, 1'b0);
    chk(msg_ovf === 1'b1, "R10 ovf", msg_ovf, 1);
    chk(msg_valid === 1'b1 && msg_id === 16'h3333, "R10 kept", msg_id, 16'h3333);
    @(posedge clk); #1 msg_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(msg_valid === 1'b0, "R10 drained", msg_valid, 0);
    chk(exp_q.size() == 0, "R10 queue empty", exp_q.size(), 0);
    clear(5'b01000);
    @(negedge clk);
    chk(msg_ovf === 1'b0, "R9 clear ovf", msg_ovf, 0);

    // error log
    perr_en = 1'b0;
    wr(1'b1, 16'h5555, 32'hB000_0000, 1'b0);
    chk(ecc_vld === 1'b0, "R11 mode1 no log", ecc_vld, 0);
    mode2 = 1'b1;
    wr(1'b1, 16'h6666, 32'hB000_0100, 1'b0);
    chk(ecc_vld === 1'b1 && ecc_id === 16'h6666, "R11 logged id", ecc_id, 16'h6666);
    chk(ecc_lo === 32'hB000_0100 && ecc_hi === ~32'hB000_0100, "R11 addr", ecc_lo, 32'hB000_0100);
    chk(ecc_attr === 32'h0000_6666, "R11 attr", ecc_attr, 32'h6666);
    wr(1'b1, 16'h7777, 32'hB000_0200, 1'b0);
    chk(ecc_id === 16'h6666 && ecc_lo === 32'hB000_0100, "R11 held", ecc_id, 16'h6666);
    clear(5'b10000);
    @(negedge clk);
    chk(ecc_vld === 1'b0 && sts_dpe === 1'b1, "R9 R11 log clear", {ecc_vld, sts_dpe}, 2'b01);

    repeat (4) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule